// File: doc/BRIEF.md
# ADC Channel Sequencer with Subsampling

The block decides, for each sequencer cycle, which ADC channel is selected and whether that channel is converted. A sequencer cycle begins with a one-clock start strobe. On each strobe the channel select moves to the next enabled channel in ascending channel order. When no enabled channel lies above the current one, the select wraps to the lowest enabled channel. One ADC cycle is one full pass through the enabled channels, so it spans as many sequencer cycles as there are enabled channels.

Within a sequencer cycle, a time counter counts timebase ticks from the start strobe. When the count reaches the programmed start time, the block issues a one-clock conversion request, unless subsampling has chosen to skip that cycle. Subsampling works on a ratio N. With N = 0, every cycle converts. With N > 0, only every Nth cycle that is subject to subsampling converts, counted in sequencer cycles. A mode flag selects which cycles are subject: every enabled channel, or only the cycles that select the lowest enabled channel. In the second mode the other channels always convert.

Top module: `adc_chan_seq`

## Requirements
- R1: While reset is asserted and after it is released, chan_sel_o is 0 and conv_req_o and round_end_o are 0 until the first start strobe.
- R2: Bit i of chan_en_i enables channel i (0 to 15). The first start strobe after reset selects the lowest enabled channel. Each later strobe selects the next enabled channel above the current one. chan_sel_o changes on the clock edge that samples the strobe.
- R3: When no enabled channel lies above the current one, a strobe selects the lowest enabled channel. round_end_o is then high for exactly the one clock after that edge. round_end_o is never high in any other clock.
- R4: The in-cycle time count is 0 in the clock after the strobe edge and rises by one on each edge where tick_i is high. conv_req_o is high for one clock when that count equals start_time_i and the cycle is not skipped. It is high at most once per sequencer cycle, even when tick_i pauses on the matching count.
- R5: With subs_ratio_i = 0, every sequencer cycle with an enabled channel issues a request.
- R6: With subs_ratio_i = N > 0 and subs_all_i = 1, every cycle is subject to subsampling. The subject cycles numbered 0, N, 2N, ... since the counter was cleared convert, and all other cycles are skipped.
- R7: With subs_all_i = 0, only cycles that select the lowest enabled channel are subject to subsampling, and only those cycles advance the decimation count. Cycles on other channels always convert.
- R8: The decimation count clears when subs_ratio_i or subs_all_i changes, and at the first start after reset. The next subject cycle then converts.
- R9: A strobe arriving while chan_en_i is all zeros leaves chan_sel_o unchanged. It issues no request, gives no round_end_o pulse and does not advance the decimation count.
- R10: Sparse masks such as channels 1, 6 and 11 only are stepped in order, skipping every disabled channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start_i | input | 1 | Sequencer cycle start strobe |
| tick_i | input | 1 | Cycle timebase tick |
| chan_en_i | input | 16 | Channel enable mask, bit i for channel i |
| start_time_i | input | 8 | Conversion start time in ticks from cycle start |
| subs_ratio_i | input | 4 | Subsampling ratio, 0 means off |
| subs_all_i | input | 1 | 1: all channels subsampled; 0: lowest enabled channel only |
| chan_sel_o | output | 4 | Selected channel |
| conv_req_o | output | 1 | One-clock conversion request |
| round_end_o | output | 1 | One-clock pulse on wrap to the lowest channel |

## Verification
The wrap pulse and the subsampling decision can land in the same cycle. A wrap always selects the lowest enabled channel, which is the one channel that is subsampled when subs_all_i is 0. The bench sweeps masks, ratios and both modes so that wrap cycles coincide with both skipped and converting counter phases. In each such cycle it judges round_end_o and conv_req_o separately against its own channel walk and decimation count. A start time of 0 also puts the request in the same clock as the channel update and the round pulse.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned DEF_NCH = 16;
  localparam int unsigned DEF_TW  = 8;
  localparam int unsigned DEF_SW  = 4;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_e;
endpackage

// File: rtl/adc_seq_pick.sv
module adc_seq_pick #(
  parameter int unsigned NCH = adc_seq_pkg::DEF_NCH,
  localparam int unsigned CW = $clog2(NCH)
) (
  input  logic [NCH-1:0] mask_i,
  input  logic [CW-1:0]  cur_i,
  output logic [CW-1:0]  low_o,
  output logic [CW-1:0]  nxt_o,
  output logic           any_o,
  output logic           wrap_o
);
  logic [CW-1:0] above;
  logic          found;

  always_comb begin
    low_o = '0;
    above = '0;
    found = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask_i[i]) begin
        low_o = CW'(i);
        if (i > int'(cur_i)) begin
          above = CW'(i);
          found = 1'b1;
        end
      end
    end
  end

  assign any_o  = |mask_i;
  assign wrap_o = ~found;
  assign nxt_o  = found ? above : low_o;
endmodule

// File: rtl/adc_seq_subs.sv
module adc_seq_subs #(
  parameter int unsigned SW = adc_seq_pkg::DEF_SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  input  logic          clr_i,
  input  logic          subject_i,
  input  logic [SW-1:0] ratio_i,
  output logic          skip_o
);
  logic [SW-1:0] cnt_q, cnt_d, eff;
  logic          active;

  assign eff    = clr_i ? '0 : cnt_q;
  assign active = subject_i & (ratio_i != '0);
  assign skip_o = active & (eff != '0);

  always_comb begin
    cnt_d = eff;
    if (adv_i && active) begin
      if ({1'b0, eff} >= ({1'b0, ratio_i} - 1'b1)) cnt_d = '0;
      else                                         cnt_d = eff + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int unsigned TW = adc_seq_pkg::DEF_TW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          arm_i,
  input  logic          tick_i,
  input  logic [TW-1:0] at_i,
  output logic          req_o
);
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic          arm_q, arm_d, done_q, done_d;

  assign req_o = arm_q & ~done_q & (tcnt_q == at_i);

  always_comb begin
    tcnt_d = tcnt_q;
    arm_d  = arm_q;
    done_d = done_q | req_o;
    if (start_i) begin
      tcnt_d = '0;
      arm_d  = arm_i;
      done_d = 1'b0;
    end else if (tick_i && (tcnt_q != '1)) begin
      tcnt_d = tcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
      arm_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      tcnt_q <= tcnt_d;
      arm_q  <= arm_d;
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/adc_chan_seq.sv
module adc_chan_seq #(
  parameter int unsigned NCH = adc_seq_pkg::DEF_NCH,
  parameter int unsigned TW  = adc_seq_pkg::DEF_TW,
  parameter int unsigned SW  = adc_seq_pkg::DEF_SW,
  localparam int unsigned CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cyc_start_i,
  input  logic           tick_i,
  input  logic [NCH-1:0] chan_en_i,
  input  logic [TW-1:0]  start_time_i,
  input  logic [SW-1:0]  subs_ratio_i,
  input  logic           subs_all_i,
  output logic [CW-1:0]  chan_sel_o,
  output logic           conv_req_o,
  output logic           round_end_o
);
  import adc_seq_pkg::*;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  run_e           run_q, run_d;
  logic [CW-1:0]  chan_q, chan_d;
  logic           round_q, round_d;
  logic [SW:0]    cfg_q, cfg_d;

  logic [CW-1:0]  low, nxt, sel_new;
  logic           any, wrap, first, start_ok, subject, cfg_chg, skip;

  adc_seq_pick #(.NCH(NCH)) u_pick (
    .mask_i (chan_en_i),
    .cur_i  (chan_q),
    .low_o  (low),
    .nxt_o  (nxt),
    .any_o  (any),
    .wrap_o (wrap)
  );

  assign first    = (run_q == ST_IDLE);
  assign start_ok = cyc_start_i & any;
  assign sel_new  = first ? low : nxt;
  assign subject  = subs_all_i | (sel_new == low);
  assign cfg_d    = {subs_ratio_i, subs_all_i};
  assign cfg_chg  = (cfg_d != cfg_q);

  adc_seq_subs #(.SW(SW)) u_subs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .adv_i     (start_ok),
    .clr_i     (cfg_chg | first),
    .subject_i (subject),
    .ratio_i   (subs_ratio_i),
    .skip_o    (skip)
  );

  adc_seq_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .start_i (cyc_start_i),
    .arm_i   (any & ~skip),
    .tick_i  (tick_i),
    .at_i    (start_time_i),
    .req_o   (conv_req_o)
  );

  // next state
  always_comb begin
    run_d   = run_q;
    chan_d  = chan_q;
    round_d = 1'b0;
    if (start_ok) begin
      run_d   = ST_RUN;
      chan_d  = sel_new;
      round_d = ~first & wrap;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      run_q   <= ST_IDLE;
      chan_q  <= '0;
      round_q <= 1'b0;
      cfg_q   <= '0;
    end else begin
      run_q   <= run_d;
      chan_q  <= chan_d;
      round_q <= round_d;
      cfg_q   <= cfg_d;
    end
  end

  assign chan_sel_o  = chan_q;
  assign round_end_o = round_q;
endmodule

// File: rtl/adc_chan_seq_chk.sv
module adc_chan_seq_chk #(
  parameter int unsigned NCH = 16,
  parameter int unsigned CW  = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cyc_start_i,
  input logic [NCH-1:0] chan_en_i,
  input logic [CW-1:0]  chan_sel_o,
  input logic           conv_req_o,
  input logic           round_end_o
);
  logic [NCH-1:0] mask_at_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           mask_at_start <= '0;
    else if (cyc_start_i) mask_at_start <= chan_en_i;
  end

  p_sel_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start_i && (chan_en_i != '0) |=> mask_at_start[chan_sel_o]);

  p_round_only_on_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_start_i |=> !round_end_o);

  p_wrap_goes_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    round_end_o |-> (chan_sel_o <= $past(chan_sel_o)));

  p_req_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req_o && !cyc_start_i |=> !conv_req_o);

  p_empty_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en_i == '0) |=> $stable(chan_sel_o));

  p_empty_noreq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start_i && (chan_en_i == '0) |=> !conv_req_o && !round_end_o);
endmodule

bind adc_chan_seq adc_chan_seq_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .cyc_start_i (cyc_start_i),
  .chan_en_i   (chan_en_i),
  .chan_sel_o  (chan_sel_o),
  .conv_req_o  (conv_req_o),
  .round_end_o (round_end_o)
);

// File: tb/adc_chan_seq_bench.sv
`timescale 1ns/1ps
module adc_chan_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_start_i = 1'b0;
  logic        tick_i = 1'b0;
  logic [15:0] chan_en_i = '0;
  logic [7:0]  start_time_i = '0;
  logic [3:0]  subs_ratio_i = '0;
  logic        subs_all_i = 1'b0;
  logic [3:0]  chan_sel_o;
  logic        conv_req_o;
  logic        round_end_o;

  always #2.5 clk = ~clk;

  adc_chan_seq u_adc_chan_seq (.*);

  int n_cmp = 0, n_bad = 0;
  int e_chan = 0, e_scnt = 0;
  bit e_run = 0, fresh_cfg = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_cfg(input logic [15:0] m, input int r, input bit a, input int st);
    if (r != int'(subs_ratio_i) || a != subs_all_i) begin
      e_scnt = 0;
      fresh_cfg = 1;
    end
    chan_en_i = m; subs_ratio_i = 4'(r); subs_all_i = a; start_time_i = 8'(st);
    @(negedge clk); @(negedge clk);
  endtask

  // one sequencer cycle of len clocks; entered and left at a negedge
  task automatic seq_cycle(input int len, input bit gap);
    int lowest = -1, sel = 0, bt = 0;
    bit wrap = 0, subject, skip, armed, fired = 0, any;
    string tg;
    any = (chan_en_i != 0);
    for (int i = 15; i >= 0; i--) if (chan_en_i[i]) lowest = i;
    if (any) begin
      if (!e_run) sel = lowest;
      else begin
        sel = -1;
        for (int i = 15; i >= 0; i--) if (chan_en_i[i] && i > e_chan) sel = i;
        if (sel < 0) begin sel = lowest; wrap = 1; end
      end
      if (!e_run) e_scnt = 0;
      subject = subs_all_i || (sel == lowest);
      skip = (subs_ratio_i != 0) && subject && (e_scnt != 0);
      if (subs_ratio_i != 0 && subject) e_scnt = (e_scnt + 1) % int'(subs_ratio_i);
      e_chan = sel; e_run = 1; armed = !skip;
    end else armed = 0;
    tg = !any ? "R9" : fresh_cfg && subject ? "R8" :
         subs_ratio_i == 0 ? "R5" : subs_all_i ? "R6" : "R7";
    if (any && subject) fresh_cfg = 0;
    cyc_start_i = 1'b1;
    @(negedge clk);
    cyc_start_i = 1'b0;
    chk(chan_en_i == 16'h0842 ? "R10 channel" : "R2 channel", chan_sel_o, e_chan);
    for (int k = 0; k < len; k++) begin
      bit ereq;
      ereq = armed && !fired && (bt == int'(start_time_i));
      if (ereq) fired = 1;
      chk({tg, " R4 request"}, conv_req_o, ereq);
      chk("R3 round end", round_end_o, (k == 0) ? wrap : 0);
      tick_i = gap ? (k % 3 != 1) : 1'b1;
      if (tick_i && bt < 255) bt++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] masks [5];
    masks = '{16'h0842, 16'h0111, 16'h8000, 16'hFFFF, 16'h0005};
    #1;
    chk("R1 sel in reset", chan_sel_o, 0);
    chk("R1 req in reset", conv_req_o, 0);
    chk("R1 round in reset", round_end_o, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 sel after reset", chan_sel_o, 0);
    chk("R1 req after reset", conv_req_o, 0);
    chk("R1 round after reset", round_end_o, 0);

    // empty mask before any channel: nothing happens
    set_cfg(16'h0000, 0, 1, 2);
    seq_cycle(6, 0);

    foreach (masks[mi])
      for (int r = 0; r < 4; r++)
        for (int a = 0; a < 2; a++)
          for (int s = 0; s < 2; s++) begin
            set_cfg(masks[mi], r, a[0], s * 5);
            for (int c = 0; c < 9; c++) seq_cycle(8, c[0]);
          end

    // R9: empty mask mid-run holds select, then resumes from it
    set_cfg(16'h0842, 2, 0, 1);
    seq_cycle(5, 0);
    chan_en_i = 16'h0000;
    seq_cycle(5, 0); seq_cycle(5, 1);
    chan_en_i = 16'h0842;
    for (int c = 0; c < 7; c++) seq_cycle(5, 0);

    // R1/R8: reset mid-run, sequencer restarts from lowest channel
    rst_n = 1'b0;
    #1;
    chk("R1 sel mid reset", chan_sel_o, 0);
    chk("R1 round mid reset", round_end_o, 0);
    e_run = 0; e_chan = 0; e_scnt = 0; fresh_cfg = 1;
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int c = 0; c < 8; c++) seq_cycle(4, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule